// File: doc/BRIEF.md
# Transfer address and count updater

This block produces the register contents a disk controller holds once a sector transfer has ended. The controller keeps a negative (two's-complement) word count, a 16-bit bus address extended by two memory-extension bits to 18 bits, and a packed disk address made of drive, track and sector fields. When the data movement is over, a completion strobe presents the starting register values, the function, the format and increment-inhibit controls, the number of words actually moved and the drive capacity. The block returns the new word count, bus address, extension bits and disk address, the overrun flag, and the number of zero words needed to pad a partial write to the end of its sector.

The transfer is trimmed at the end of the drive. The memory address either stays frozen or advances two bytes per word. The disk address moves forward to the next sector boundary after the last word. In a format read, each word moved stands for one whole sector. The outputs load on the clock edge that samples the strobe, and a one-cycle done pulse follows on the next edge.

Top module: `xfer_upd`

## Requirements
- R1: The requested count is 65536 minus `wc_in`, so `wc_in` = 0 requests 65536 words. The words counted as moved are the smallest of `moved_in`, the requested count and the room left on the drive. `wc_out` = (`wc_in` + moved) mod 65536.
- R2: The memory address has 18 bits: `ext_in` supplies bits 17:16 and `ba_in` supplies bits 15:0, with bit 0 forced to 0. Without inhibit, the address grows by 2 per moved word modulo 2^18. `ba_out` gets bits 15:0 (bit 0 always 0) and `ext_out` gets bits 17:16, which takes the carry.
- R3: With `inh` = 1, `ba_out` equals `ba_in` with bit 0 cleared and `ext_out` equals `ext_in`.
- R4: The start word is (track × 12 + sector) × 256, with sector taken from `da_in[3:0]` and track from `da_in[12:4]`. Outside a format read, `overrun` = 1 when start + requested > `capacity`. The moved count is then limited to `capacity` − start, or 0 if the start lies beyond the capacity.
- R5: Outside a format read, the new linear sector is (start + moved + 255) / 256. `da_out[3:0]` holds that sector mod 12 and `da_out[12:4]` holds that sector / 12, so a zero-length transfer leaves the sector and track unchanged.
- R6: A format read is `fmt` = 1 with `func` = 2. In a format read, each moved word counts as one sector. Room is measured in whole sectors, (`capacity` − start) / 256. `overrun` is set when the requested count exceeds that room. The new linear sector is the start sector plus moved.
- R7: `da_out[15:13]` equals `da_in[15:13]`.
- R8: A track value past 511 wraps modulo 512 inside `da_out[12:4]`, and no error is flagged.
- R9: For `func` = 1 (write), `pad_out` = (256 − moved mod 256) mod 256. For every other function code, `pad_out` = 0.
- R10: All results load on the rising edge that samples `start` = 1. `done` is high for exactly the following cycle. Between strobes, the results hold whatever the inputs do.
- R11: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Completion strobe, one cycle |
| wc_in | input | 16 | Starting word count (negative of request) |
| ba_in | input | 16 | Starting bus address |
| ext_in | input | 2 | Starting memory-extension bits |
| da_in | input | 16 | Starting disk address (drive 15:13, track 12:4, sector 3:0) |
| func | input | 3 | Function code (1 write, 2 read, 3 write check, 5 read check) |
| fmt | input | 1 | Format mode |
| inh | input | 1 | Memory address increment inhibit |
| moved_in | input | 17 | Words the data path moved |
| capacity | input | 21 | Drive capacity in words |
| wc_out | output | 16 | Updated word count |
| ba_out | output | 16 | Updated bus address |
| ext_out | output | 2 | Updated extension bits |
| da_out | output | 16 | Updated disk address |
| pad_out | output | 8 | Zero words to pad a write to its sector end |
| overrun | output | 1 | Transfer cut at the end of the drive |
| done | output | 1 | One-cycle pulse after results load |

## Verification
The stimulus has several parts:
- A plain full-sector read checks that count, address and disk address move together.
- The same read with inhibit set separates the frozen address from the advancing one.
- A bus address at the top of its 16-bit range shows whether the carry reaches the extension bits, including the wrap at 2^18.
- A zero-valued count register checks the 65536-word case.
- A partial write and a zero-length transfer separate rounding up from no movement.
- Transfers near the last sector, in both ordinary and format reads, check that room is counted in words in one mode and in sectors in the other.
- A format read from track 511 exposes the track wrap.
- A moved count larger than requested shows that the request limits it.
- Changing inputs with no strobe checks that the results hold.

// File: rtl/xfu_pkg.sv
package xfu_pkg;

    localparam int unsigned XFU_WC_W = 16;
    localparam int unsigned XFU_EXT_W = 2;
    localparam int unsigned XFU_SECT_W = 4;
    localparam int unsigned XFU_TRK_W = 9;
    localparam int unsigned XFU_DRV_W = 3;
    localparam int unsigned XFU_SPT = 12;
    localparam int unsigned XFU_WPS = 256;
    localparam int unsigned XFU_CAP_W = 21;

    typedef enum logic [2:0] {
        FN_CLEAR = 3'd0,
        FN_WRITE = 3'd1,
        FN_READ  = 3'd2,
        FN_WCHK  = 3'd3,
        FN_SEEK  = 3'd4,
        FN_RCHK  = 3'd5,
        FN_DRST  = 3'd6,
        FN_LOCK  = 3'd7
    } xfu_fn_e;

    // Format read: each moved word stands for a full sector
    function automatic logic fmt_read(input logic [2:0] fn, input logic fmt);
        return fmt && (fn == FN_READ);
    endfunction

endpackage

// File: rtl/xfu_clip.sv
module xfu_clip
    import xfu_pkg::*;
#(
    parameter int unsigned WC_W   = XFU_WC_W,
    parameter int unsigned SECT_W = XFU_SECT_W,
    parameter int unsigned TRK_W  = XFU_TRK_W,
    parameter int unsigned SPT    = XFU_SPT,
    parameter int unsigned WPS    = XFU_WPS,
    parameter int unsigned CAP_W  = XFU_CAP_W,
    parameter int unsigned AW     = CAP_W + 3
) (
    input  logic [WC_W-1:0]   wc,
    input  logic [SECT_W-1:0] sect,
    input  logic [TRK_W-1:0]  trk,
    input  logic              fmt_rd,
    input  logic [WC_W:0]     moved,
    input  logic [CAP_W-1:0]  cap,
    output logic [AW-1:0]     start_lin,
    output logic [AW-1:0]     start_word,
    output logic [WC_W:0]     eff,
    output logic              ovr
);
    localparam int unsigned CNT_W = WC_W + 1;
    localparam int unsigned SH    = $clog2(WPS);

    logic [CNT_W-1:0] req;
    logic [CNT_W-1:0] lim;
    logic [AW-1:0]    room_w;
    logic [AW-1:0]    room;

    always_comb begin
        start_lin  = AW'(trk) * AW'(SPT) + AW'(sect);
        start_word = start_lin << SH;
        // two's-complement count: zero register asks for the full range
        req        = {1'b1, {WC_W{1'b0}}} - {1'b0, wc};
        room_w     = (AW'(cap) > start_word) ? (AW'(cap) - start_word) : '0;
        room       = fmt_rd ? (room_w >> SH) : room_w;
        ovr        = AW'(req) > room;
        lim        = ovr ? CNT_W'(room) : req;
        eff        = (moved < lim) ? moved : lim;
    end

endmodule

// File: rtl/xfu_mem_adv.sv
module xfu_mem_adv
    import xfu_pkg::*;
#(
    parameter int unsigned WC_W  = XFU_WC_W,
    parameter int unsigned EXT_W = XFU_EXT_W
) (
    input  logic [WC_W-1:0]  ba,
    input  logic [EXT_W-1:0] ext,
    input  logic             inh,
    input  logic [WC_W:0]    eff,
    output logic [WC_W-1:0]  ba_n,
    output logic [EXT_W-1:0] ext_n
);
    localparam int unsigned MA_W = WC_W + EXT_W;

    logic [MA_W-1:0] ma;
    logic [MA_W-1:0] step;
    logic [MA_W-1:0] ma_n;

    always_comb begin
        ma    = {ext, ba} & ~MA_W'(1);
        step  = inh ? '0 : (MA_W'(eff) << 1);
        ma_n  = ma + step;
        ba_n  = ma_n[WC_W-1:0];
        ext_n = ma_n[MA_W-1:WC_W];
    end

endmodule

// File: rtl/xfu_da_adv.sv
module xfu_da_adv
    import xfu_pkg::*;
#(
    parameter int unsigned WC_W   = XFU_WC_W,
    parameter int unsigned SECT_W = XFU_SECT_W,
    parameter int unsigned TRK_W  = XFU_TRK_W,
    parameter int unsigned DRV_W  = XFU_DRV_W,
    parameter int unsigned SPT    = XFU_SPT,
    parameter int unsigned WPS    = XFU_WPS,
    parameter int unsigned AW     = XFU_CAP_W + 3
) (
    input  logic [AW-1:0]                   start_lin,
    input  logic [AW-1:0]                   start_word,
    input  logic [WC_W:0]                   eff,
    input  logic                            fmt_rd,
    input  logic [DRV_W-1:0]                drv,
    output logic [DRV_W+TRK_W+SECT_W-1:0]   da_n
);
    localparam int unsigned SH = $clog2(WPS);

    logic [AW-1:0] nl;

    always_comb begin
        if (fmt_rd)
            nl = start_lin + AW'(eff);
        else
            nl = (start_word + AW'(eff) + AW'(WPS - 1)) >> SH;
        // track truncates to its field width: wrap, not an error
        da_n = {drv, TRK_W'(nl / AW'(SPT)), SECT_W'(nl % AW'(SPT))};
    end

endmodule

// File: rtl/xfer_upd.sv
module xfer_upd
    import xfu_pkg::*;
#(
    parameter int unsigned WC_W   = XFU_WC_W,
    parameter int unsigned EXT_W  = XFU_EXT_W,
    parameter int unsigned SECT_W = XFU_SECT_W,
    parameter int unsigned TRK_W  = XFU_TRK_W,
    parameter int unsigned DRV_W  = XFU_DRV_W,
    parameter int unsigned SPT    = XFU_SPT,
    parameter int unsigned WPS    = XFU_WPS,
    parameter int unsigned CAP_W  = XFU_CAP_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic [WC_W-1:0]                wc_in,
    input  logic [WC_W-1:0]                ba_in,
    input  logic [EXT_W-1:0]               ext_in,
    input  logic [DRV_W+TRK_W+SECT_W-1:0]  da_in,
    input  logic [2:0]                     func,
    input  logic                           fmt,
    input  logic                           inh,
    input  logic [WC_W:0]                  moved_in,
    input  logic [CAP_W-1:0]               capacity,
    output logic [WC_W-1:0]                wc_out,
    output logic [WC_W-1:0]                ba_out,
    output logic [EXT_W-1:0]               ext_out,
    output logic [DRV_W+TRK_W+SECT_W-1:0]  da_out,
    output logic [$clog2(WPS)-1:0]         pad_out,
    output logic                           overrun,
    output logic                           done
);
    localparam int unsigned DA_W  = DRV_W + TRK_W + SECT_W;
    localparam int unsigned CNT_W = WC_W + 1;
    localparam int unsigned SH    = $clog2(WPS);
    localparam int unsigned AW    = CAP_W + 3;

    logic              fmt_rd;
    logic [AW-1:0]     start_lin;
    logic [AW-1:0]     start_word;
    logic [CNT_W-1:0]  eff;
    logic              ovr_n;
    logic [WC_W-1:0]   ba_n;
    logic [EXT_W-1:0]  ext_n;
    logic [DA_W-1:0]   da_n;
    logic [SH-1:0]     pad_n;
    logic              pend;

    assign fmt_rd = fmt_read(func, fmt);

    xfu_clip #(
        .WC_W(WC_W), .SECT_W(SECT_W), .TRK_W(TRK_W), .SPT(SPT),
        .WPS(WPS), .CAP_W(CAP_W), .AW(AW)
    ) u_clip (
        .wc(wc_in),
        .sect(da_in[SECT_W-1:0]),
        .trk(da_in[SECT_W +: TRK_W]),
        .fmt_rd(fmt_rd),
        .moved(moved_in),
        .cap(capacity),
        .start_lin(start_lin),
        .start_word(start_word),
        .eff(eff),
        .ovr(ovr_n)
    );

    xfu_mem_adv #(.WC_W(WC_W), .EXT_W(EXT_W)) u_mem (
        .ba(ba_in),
        .ext(ext_in),
        .inh(inh),
        .eff(eff),
        .ba_n(ba_n),
        .ext_n(ext_n)
    );

    xfu_da_adv #(
        .WC_W(WC_W), .SECT_W(SECT_W), .TRK_W(TRK_W), .DRV_W(DRV_W),
        .SPT(SPT), .WPS(WPS), .AW(AW)
    ) u_da (
        .start_lin(start_lin),
        .start_word(start_word),
        .eff(eff),
        .fmt_rd(fmt_rd),
        .drv(da_in[DA_W-1 -: DRV_W]),
        .da_n(da_n)
    );

    // zero fill to the sector end only for a write
    assign pad_n = (func == FN_WRITE) ? SH'(CNT_W'(0) - eff) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wc_out  <= '0;
            ba_out  <= '0;
            ext_out <= '0;
            da_out  <= '0;
            pad_out <= '0;
            overrun <= 1'b0;
            pend    <= 1'b0;
            done    <= 1'b0;
        end else begin
            pend <= start;
            done <= pend;
            if (start) begin
                wc_out  <= wc_in + WC_W'(eff);
                ba_out  <= ba_n;
                ext_out <= ext_n;
                da_out  <= da_n;
                pad_out <= pad_n;
                overrun <= ovr_n;
            end
        end
    end

    p_done_lag_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> ##1 done);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(wc_out) && $stable(da_out) && $stable(ba_out) && $stable(ext_out)));

    p_inhibit_r3: assert property (@(posedge clk) disable iff (rst)
        (start && inh) |=> (ba_out == ($past(ba_in) & ~WC_W'(1)) && ext_out == $past(ext_in)));

    p_drive_keep_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> (da_out[DA_W-1 -: DRV_W] == $past(da_in[DA_W-1 -: DRV_W])));

    p_even_addr_r2: assert property (@(posedge clk) disable iff (rst)
        ba_out[0] == 1'b0);

    p_no_pad_r9: assert property (@(posedge clk) disable iff (rst)
        (start && func != FN_WRITE) |=> (pad_out == '0));

endmodule

// File: tb/sim_xfer_upd.sv
`timescale 1ns/1ps
module sim_xfer_upd;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] wc_in = '0;
    logic [15:0] ba_in = '0;
    logic [1:0]  ext_in = '0;
    logic [15:0] da_in = '0;
    logic [2:0]  func = '0;
    logic        fmt = 1'b0;
    logic        inh = 1'b0;
    logic [16:0] moved_in = '0;
    logic [20:0] capacity = '0;
    logic [15:0] wc_out;
    logic [15:0] ba_out;
    logic [1:0]  ext_out;
    logic [15:0] da_out;
    logic [7:0]  pad_out;
    logic        overrun;
    logic        done;

    always #2 clk = ~clk;

    xfer_upd u0 (
        .clk(clk), .rst(rst), .start(start),
        .wc_in(wc_in), .ba_in(ba_in), .ext_in(ext_in), .da_in(da_in),
        .func(func), .fmt(fmt), .inh(inh), .moved_in(moved_in),
        .capacity(capacity),
        .wc_out(wc_out), .ba_out(ba_out), .ext_out(ext_out),
        .da_out(da_out), .pad_out(pad_out), .overrun(overrun), .done(done)
    );

    typedef struct {
        string tag;
        int    wc;
        int    ba;
        int    ext;
        int    da;
        int    pad;
        int    ovr;
    } exp_t;

    exp_t  sb[$];
    exp_t  last;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;

    task automatic cmp(input string tag, input string what, input int act, input int expv, inout bit bad);
        if (act != expv) begin
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
            bad = 1;
        end
    endtask

    // expected values worked out from the requirement text
    task automatic apply(input string tag, input int wc, input int ba, input int ext,
                         input int drv, input int trk, input int sec, input int fn,
                         input bit fm, input bit ih, input int mv, input int cap);
        exp_t e;
        longint req, lin, sw, roomw, room, lim, eff, ma, nl;
        bit     fr;
        fr    = fm && (fn == 2);
        req   = (wc == 0) ? 65536 : 65536 - wc;
        lin   = trk * 12 + sec;
        sw    = lin * 256;
        roomw = (cap > sw) ? cap - sw : 0;
        room  = fr ? roomw / 256 : roomw;
        lim   = (req > room) ? room : req;
        eff   = (mv < lim) ? mv : lim;
        ma    = ext * 65536 + (ba & 16'hFFFE);
        if (!ih) ma = (ma + 2 * eff) % 262144;
        nl    = fr ? lin + eff : (sw + eff + 255) / 256;
        e.tag = tag;
        e.wc  = int'((wc + eff) % 65536);
        e.ba  = int'(ma % 65536);
        e.ext = int'(ma / 65536);
        e.da  = int'(drv * 8192 + ((nl / 12) % 512) * 16 + (nl % 12));
        e.pad = (fn == 1) ? int'((256 - eff % 256) % 256) : 0;
        e.ovr = (req > room) ? 1 : 0;
        sb.push_back(e);
        last = e;
        @(negedge clk);
        wc_in    = 16'(wc);
        ba_in    = 16'(ba);
        ext_in   = 2'(ext);
        da_in    = 16'(drv * 8192 + trk * 16 + sec);
        func     = 3'(fn);
        fmt      = fm;
        inh      = ih;
        moved_in = 17'(mv);
        capacity = 21'(cap);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops one expectation per done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                bit   bad;
                exp_t e;
                bad = 0;
                n_chk++;
                if (sb.size() == 0) begin
                    $display("FAIL R10 unexpected done: actual 1 expected 0");
                    n_bad++;
                end else begin
                    e = sb.pop_front();
                    cmp(e.tag, "wc_out",  int'(wc_out),  e.wc,  bad);
                    cmp(e.tag, "ba_out",  int'(ba_out),  e.ba,  bad);
                    cmp(e.tag, "ext_out", int'(ext_out), e.ext, bad);
                    cmp(e.tag, "da_out",  int'(da_out),  e.da,  bad);
                    cmp(e.tag, "pad_out", int'(pad_out), e.pad, bad);
                    cmp(e.tag, "overrun", int'(overrun), e.ovr, bad);
                    if (bad) n_bad++;
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: pending results actual %0d expected 0", sb.size());
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        localparam int CAP = 1247232;
        repeat (3) @(negedge clk);
        // R11: reset state
        n_chk++;
        if (wc_out != 0 || ba_out != 0 || ext_out != 0 || da_out != 0 ||
            pad_out != 0 || overrun != 0 || done != 0) begin
            n_bad++;
            $display("FAIL R11 reset outputs: actual %0h/%0h/%0h/%0h expected 0",
                     wc_out, ba_out, da_out, done);
        end
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R2 R5: plain full-sector read
        apply("R5_read",     16'hFF00, 16'h1000, 0, 2, 3, 5, 2, 0, 0, 256, CAP);
        // R3: same read, address frozen
        apply("R3_inhibit",  16'hFF00, 16'h1001, 1, 2, 3, 5, 2, 0, 1, 256, CAP);
        // R2: carry into extension bits
        apply("R2_carry",    16'hFFFE, 16'hFFFE, 1, 0, 0, 0, 2, 0, 0, 2, CAP);
        // R2: wrap past 18 bits
        apply("R2_wrap",     16'hFFFE, 16'hFFFE, 3, 1, 7, 2, 3, 0, 0, 2, CAP);
        // R9: partial write, padding
        apply("R9_pad",      16'hFF9C, 16'h0200, 0, 4, 10, 11, 1, 0, 0, 100, CAP);
        // R5: zero-length transfer keeps sector
        apply("R5_zero",     16'hFF00, 16'h0400, 0, 5, 20, 7, 1, 0, 0, 0, CAP);
        // R4: overrun on the last sector
        apply("R4_overrun",  16'hFE00, 16'h0000, 0, 3, 405, 11, 2, 0, 0, 512, CAP);
        // R6: format read counts sectors
        apply("R6_fmt",      16'hFFFD, 16'h0100, 0, 6, 10, 0, 2, 1, 0, 3, CAP);
        // R6: format read overrun in sectors
        apply("R6_fmt_ovr",  16'hFFFB, 16'h0100, 0, 6, 405, 10, 2, 1, 0, 5, CAP);
        // R8 R7: track wraps past 511, drive kept
        apply("R8_wrap",     16'hFFE8, 16'h0000, 0, 7, 511, 0, 2, 1, 0, 24, 2000000);
        // R1: zero register means 65536 words
        apply("R1_full",     16'h0000, 16'h0000, 0, 1, 0, 0, 2, 0, 0, 65536, CAP);
        // R1: moved limited by request
        apply("R1_limit",    16'hFFF6, 16'h0010, 0, 0, 1, 1, 3, 0, 0, 20, CAP);
        // R6: format flag ignored outside read
        apply("R6_fmt_wr",   16'hFFFD, 16'h0100, 0, 6, 10, 0, 1, 1, 0, 3, CAP);
        // R4: start beyond capacity moves nothing
        apply("R4_beyond",   16'hFF00, 16'h0800, 0, 2, 300, 0, 5, 0, 0, 256, 100000);

        // R10: inputs change without strobe, results hold
        @(negedge clk);
        wc_in = 16'h1234; ba_in = 16'h4444; da_in = 16'hFFFF; moved_in = 17'd77;
        repeat (4) @(negedge clk);
        n_chk++;
        if (int'(wc_out) != last.wc || int'(da_out) != last.da ||
            int'(ba_out) != last.ba || done != 1'b0) begin
            n_bad++;
            $display("FAIL R10 hold: actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     wc_out, da_out, ba_out, last.wc, last.da, last.ba);
        end

        repeat (4) @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R10 missing done: actual %0d pending expected 0", sb.size());
        end
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule